// File: doc/BRIEF.md
# Bus Error and Parity Flag Unit

This unit watches the completion of accesses to one memory region and keeps a sticky record of what went wrong. On each completed read it checks byte-lane parity on the 32-bit read data against four parity bits, with a selectable odd or even convention and a master enable. It also takes one-cycle strobes that report a bus error on a read or on a write. A source input tells whether the access came from the processor or from the DMA engine, and each source has its own group of three flags.

Software reads the flags through a simple register port. A write of zero to a flag clears it, and a write of one leaves it alone. An error-pending output goes high whenever any flag is set. An optional report pulse tells the processor, on its next completed data read, that a write bus error is still pending. Arbitration and trap handling sit outside the unit.

Top module: `bus_err_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, `flag_rdata` reads all zeros. Bits 31..7 and bit 3 of `flag_rdata` always read 0.
- R2: A cycle with `rd_err_stb` high sets bit 2 when `src_dma`=0 (processor) or bit 6 when `src_dma`=1 (DMA). The new value is visible on `flag_rdata` after the next rising edge.
- R3: A cycle with `wr_err_stb` high sets bit 1 when `src_dma`=0 or bit 5 when `src_dma`=1, with the same timing as R2.
- R4: When `rd_done`=1 and `par_en`=1, byte lane i (bits 8i+7..8i of `rd_data`) is checked together with `rd_par[i]`. With `par_even`=0, a lane is correct when the nine bits hold an odd number of ones. With `par_even`=1, a lane is correct when they hold an even number of ones. If any lane is wrong, bit 0 is set (processor) or bit 4 is set (DMA).
- R5: Parity flags (bits 0 and 4) never set in a cycle where `par_en`=0 or `rd_done`=0, whatever the data and parity bits are.
- R6: A set flag stays set until software clears it.
- R7: When `flag_wr`=1, every flag whose bit in `flag_wdata` is 0 is cleared after the edge. Every flag whose bit is 1 keeps its value.
- R8: If a flag is set by hardware and cleared by software in the same cycle, it ends up set.
- R9: `err_pending` is high exactly when at least one flag in `flag_rdata` is 1.
- R10: `wr_err_report` is high for exactly the one cycle after a cycle in which `rd_done`=1, `src_dma`=0, `wr_rpt_en`=1 and bit 1 already read 1. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_dma | input | 1 | Access source: 0 processor, 1 DMA |
| rd_done | input | 1 | A read completes this cycle |
| rd_data | input | 32 | Read data |
| rd_par | input | 4 | One parity bit per byte lane |
| par_en | input | 1 | Parity checking enable |
| par_even | input | 1 | Parity convention: 0 odd, 1 even |
| rd_err_stb | input | 1 | Bus error on a read |
| wr_err_stb | input | 1 | Bus error on a write |
| wr_rpt_en | input | 1 | Enable the pending write error report |
| flag_wr | input | 1 | Register write strobe (clear by zero) |
| flag_wdata | input | 32 | Register write data |
| flag_rdata | output | 32 | Flag register read value |
| err_pending | output | 1 | OR of all flags |
| wr_err_report | output | 1 | Pending write error reported on a processor read |

## Verification
Every flag change and the `wr_err_report` pulse appear one rising edge after the input cycle that caused them. `flag_rdata` and `err_pending` follow the flag register without any further delay. The bench drives each input cycle at the falling edge and lets one rising edge pass. At the next falling edge it compares the outputs with a bench model that was advanced by the same input cycle. For R10, the model works out its expectation from the flag value it held before that advance, because the design samples the old value of bit 1.

// File: rtl/bef_pkg.sv
// Package: shared constants for the bus error and parity flag unit.
// Assumes: two access sources (processor, DMA), each owning a nibble of
// the flag register with parity, write-error and read-error bits.
package bef_pkg;
    localparam int SRC_N      = 2;              // processor, DMA
    localparam int GRP_STRIDE = 4;              // bits per source group
    localparam int FLAG_W     = GRP_STRIDE * (SRC_N - 1) + 3;
    localparam int OFS_PAR    = 0;              // parity read error
    localparam int OFS_WR     = 1;              // write bus error
    localparam int OFS_RD     = 2;              // read bus error
    localparam int SRC_CPU    = 0;
    localparam int SRC_DMA    = 1;
    localparam int PAR_OK_IDX = 0;

    // Error events of a single cycle, before routing by source
    typedef struct packed {
        logic rd_bus;
        logic wr_bus;
        logic parity;
    } err_evt_t;

    // Mask of implemented flag bits (reserved bits stay zero)
    function automatic logic [FLAG_W-1:0] valid_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        for (int s = 0; s < SRC_N; s++) begin
            m[s*GRP_STRIDE + OFS_PAR] = 1'b1;
            m[s*GRP_STRIDE + OFS_WR]  = 1'b1;
            m[s*GRP_STRIDE + OFS_RD]  = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/bef_parity_check.sv
// Module: byte-lane parity checker.
// Checks each lane of read data with its parity bit under the selected
// convention. Purely combinational; an error is flagged only on a
// completed read while checking is enabled.
module bef_parity_check #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              chk_valid,
    input  logic              chk_en,
    input  logic              even_sel,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  par,
    output logic [LANES-1:0]  lane_bad,
    output logic              any_bad
);
    logic [LANES-1:0] lane_xor;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Fold one lane and its parity bit into a single xor bit
            always_comb begin
                lane_xor[g] = (^data[g*LANE_W +: LANE_W]) ^ par[g];
            end
            // Odd rule wants xor=1, even rule wants xor=0
            always_comb begin
                lane_bad[g] = chk_valid && chk_en && (lane_xor[g] == even_sel);
            end
        end
    endgenerate

    // Any failing lane marks the read as a parity error
    always_comb begin
        any_bad = |lane_bad;
    end
endmodule

// File: rtl/bef_event_route.sv
// Module: routes the events of one cycle to flag-set bits by source.
// Assumes the source select is valid whenever any event is present.
module bef_event_route
    import bef_pkg::*;
(
    input  logic              src_dma,
    input  err_evt_t          evt,
    output logic [FLAG_W-1:0] set_vec
);
    logic [SRC_N-1:0] src_hit;

    // Decode the source into a one-hot hit vector
    always_comb begin
        src_hit          = '0;
        src_hit[SRC_CPU] = !src_dma;
        src_hit[SRC_DMA] = src_dma;
    end

    generate
        for (genvar s = 0; s < SRC_N; s++) begin : g_src
            // Place each event into the group of its source
            always_comb begin
                set_vec[s*GRP_STRIDE + OFS_PAR] = src_hit[s] && evt.parity;
                set_vec[s*GRP_STRIDE + OFS_WR]  = src_hit[s] && evt.wr_bus;
                set_vec[s*GRP_STRIDE + OFS_RD]  = src_hit[s] && evt.rd_bus;
            end
        end
        for (genvar r = 0; r < SRC_N - 1; r++) begin : g_rsv
            // Gap bit between groups is reserved and never set
            always_comb begin
                set_vec[r*GRP_STRIDE + 3] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/bef_flag_reg.sv
// Module: sticky flag register with clear-by-zero software writes.
// A hardware set in the same cycle as a software clear wins. Bits
// outside VALID_MASK are held at zero.
module bef_flag_reg #(
    parameter int               FLAG_W     = 7,
    parameter logic [FLAG_W-1:0] VALID_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] keep_mask,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] kept;
    logic [FLAG_W-1:0] flags_nx;

    // Apply the software clear: zeros in the write data drop flags
    always_comb begin
        kept = clr_we ? (flags & keep_mask) : flags;
    end

    // Merge hardware sets after the clear so a set wins
    always_comb begin
        flags_nx = (kept | set_vec) & VALID_MASK;
    end

    // Hold the flags, cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nx;
    end
endmodule

// File: rtl/bus_err_flag_unit.sv
// Module: top of the bus error and parity flag unit.
// Collects read/write bus errors and read parity errors per source into
// a sticky register, exposes it on a simple read/clear port, and raises
// a one-cycle report when a processor read completes while a processor
// write error is pending and reporting is enabled.
module bus_err_flag_unit
    import bef_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int REG_W  = 32,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_dma,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              rd_err_stb,
    input  logic              wr_err_stb,
    input  logic              wr_rpt_en,
    input  logic              flag_wr,
    input  logic [REG_W-1:0]  flag_wdata,
    output logic [REG_W-1:0]  flag_rdata,
    output logic              err_pending,
    output logic              wr_err_report
);
    localparam logic [FLAG_W-1:0] VMASK = valid_mask();

    logic [LANES-1:0]  lane_bad;
    logic              par_bad;
    err_evt_t          evt;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags;
    logic              rpt_hit;

    bef_parity_check #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_par (
        .chk_valid (rd_done),
        .chk_en    (par_en),
        .even_sel  (par_even),
        .data      (rd_data),
        .par       (rd_par),
        .lane_bad  (lane_bad),
        .any_bad   (par_bad)
    );

    // Bundle the events of this cycle
    always_comb begin
        evt.parity = par_bad;
        evt.wr_bus = wr_err_stb;
        evt.rd_bus = rd_err_stb;
    end

    bef_event_route u_route (
        .src_dma (src_dma),
        .evt     (evt),
        .set_vec (set_vec)
    );

    bef_flag_reg #(
        .FLAG_W     (FLAG_W),
        .VALID_MASK (VMASK)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_we    (flag_wr),
        .keep_mask (flag_wdata[FLAG_W-1:0]),
        .flags     (flags)
    );

    // Processor read finishing while its write error is already pending
    always_comb begin
        rpt_hit = rd_done && !src_dma && wr_rpt_en
                  && flags[SRC_CPU*GRP_STRIDE + OFS_WR];
    end

    // Register the report as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err_report <= 1'b0;
        else        wr_err_report <= rpt_hit;
    end

    // Zero-extend the flags onto the read port
    always_comb begin
        flag_rdata             = '0;
        flag_rdata[FLAG_W-1:0] = flags;
    end

    // Summarise all flags into one pending line
    always_comb begin
        err_pending = |flags;
    end
endmodule

// File: rtl/bef_chk.sv
// Checker: temporal properties of the flag unit, bound to the top.
module bef_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        src_dma,
    input logic        rd_done,
    input logic        par_en,
    input logic        rd_err_stb,
    input logic        wr_rpt_en,
    input logic        flag_wr,
    input logic [31:0] flag_wdata,
    input logic [31:0] flag_rdata,
    input logic        err_pending,
    input logic        wr_err_report
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata[31:7] == '0) && !flag_rdata[3]);

    // R5
    no_par_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_en || !rd_done) |=> (!$rose(flag_rdata[0]) && !$rose(flag_rdata[4])));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag_rdata & $past(flag_rdata)) == $past(flag_rdata)));

    // R7
    write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ((flag_rdata & $past(flag_rdata & flag_wdata))
                     == $past(flag_rdata & flag_wdata)));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err_stb && !src_dma && flag_wr && !flag_wdata[2]) |=> flag_rdata[2]);

    // R9
    pending_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pending == (flag_rdata != '0));

    // R10
    report_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !src_dma && wr_rpt_en && flag_rdata[1]) |=> wr_err_report);

    // R10
    report_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && !src_dma && wr_rpt_en && flag_rdata[1]) |=> !wr_err_report);
endmodule

bind bus_err_flag_unit bef_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_dma       (src_dma),
    .rd_done       (rd_done),
    .par_en        (par_en),
    .rd_err_stb    (rd_err_stb),
    .wr_rpt_en     (wr_rpt_en),
    .flag_wr       (flag_wr),
    .flag_wdata    (flag_wdata),
    .flag_rdata    (flag_rdata),
    .err_pending   (err_pending),
    .wr_err_report (wr_err_report)
);

// File: tb/sim_bus_err_flag_unit.sv
module sim_bus_err_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_dma = 1'b0, rd_done = 1'b0, par_en = 1'b0, par_even = 1'b0;
    logic        rd_err_stb = 1'b0, wr_err_stb = 1'b0, wr_rpt_en = 1'b0, flag_wr = 1'b0;
    logic [31:0] rd_data = '0, flag_wdata = '0;
    logic [3:0]  rd_par = '0;
    logic [31:0] flag_rdata;
    logic        err_pending, wr_err_report;

    int tests = 0, fails = 0;
    logic [6:0] mflags = '0;
    logic       mrpt = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bus_err_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .src_dma(src_dma), .rd_done(rd_done),
        .rd_data(rd_data), .rd_par(rd_par), .par_en(par_en), .par_even(par_even),
        .rd_err_stb(rd_err_stb), .wr_err_stb(wr_err_stb), .wr_rpt_en(wr_rpt_en),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flag_rdata(flag_rdata),
        .err_pending(err_pending), .wr_err_report(wr_err_report)
    );

    // Per-lane parity rule of R4
    function automatic logic parity_fails(logic [31:0] d, logic [3:0] p, logic ev);
        for (int i = 0; i < 4; i++) begin
            int n;
            n = $countones({d[8*i +: 8], p[i]});
            if (ev ? (n % 2 == 1) : (n % 2 == 0)) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Parity bits that make every lane correct under a rule
    function automatic logic [3:0] good_par(logic [31:0] d, logic ev);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (^d[8*i +: 8]) ^ !ev;
        return p;
    endfunction

    // Next flag value from R2/R3/R4/R5/R7/R8
    function automatic logic [6:0] model_next(logic [6:0] f);
        logic [6:0] n;
        int base;
        n = flag_wr ? (f & flag_wdata[6:0]) : f;
        base = src_dma ? 4 : 0;
        if (rd_err_stb) n[base + 2] = 1'b1;
        if (wr_err_stb) n[base + 1] = 1'b1;
        if (rd_done && par_en && parity_fails(rd_data, rd_par, par_even)) n[base] = 1'b1;
        return n & 7'h77;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: model steps at the edge, outputs compared at the falling edge
    task automatic cycle();
        @(posedge clk);
        mrpt   = rd_done && !src_dma && wr_rpt_en && mflags[1];
        mflags = model_next(mflags);
        @(negedge clk);
        chk("R6/R7 flag register", flag_rdata, {25'b0, mflags});
        chk("R9 err_pending", {31'b0, err_pending}, {31'b0, (mflags != 0)});
        chk("R10 wr_err_report", {31'b0, wr_err_report}, {31'b0, mrpt});
    endtask

    task automatic idle();
        rd_done = 0; rd_err_stb = 0; wr_err_stb = 0; flag_wr = 0;
    endtask

    task automatic clear_all();
        idle(); flag_wr = 1; flag_wdata = '0; cycle(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset value
        chk("R1 reset value", flag_rdata, 32'h0);
        chk("R9 pending after reset", {31'b0, err_pending}, 32'h0);

        // R2: processor read bus error
        src_dma = 0; rd_err_stb = 1; cycle(); idle();
        chk("R2 processor read error bit2", {31'b0, flag_rdata[2]}, 32'h1);
        // R2: DMA read bus error
        src_dma = 1; rd_err_stb = 1; cycle(); idle();
        chk("R2 DMA read error bit6", {31'b0, flag_rdata[6]}, 32'h1);
        // R3: write bus errors
        src_dma = 1; wr_err_stb = 1; cycle(); idle();
        chk("R3 DMA write error bit5", {31'b0, flag_rdata[5]}, 32'h1);
        src_dma = 0; wr_err_stb = 1; cycle(); idle();
        chk("R3 processor write error bit1", {31'b0, flag_rdata[1]}, 32'h1);
        // R6: idle cycles keep flags
        cycle(); cycle();
        chk("R6 sticky", flag_rdata, 32'h66);
        // R7: writing ones keeps, zero clears bit 6 only
        flag_wr = 1; flag_wdata = 32'hFFFF_FFBF; cycle(); idle();
        chk("R7 clear by zero", flag_rdata, 32'h26);
        // R10: report fires on processor read with bit1 pending
        wr_rpt_en = 1; src_dma = 0; rd_done = 1; par_en = 0; cycle(); idle();
        chk("R10 report pulse", {31'b0, wr_err_report}, 32'h1);
        cycle();
        chk("R10 report one cycle", {31'b0, wr_err_report}, 32'h0);
        wr_rpt_en = 0; rd_done = 1; cycle(); idle();
        chk("R10 disabled no report", {31'b0, wr_err_report}, 32'h0);
        wr_rpt_en = 1; src_dma = 1; rd_done = 1; cycle(); idle();
        chk("R10 DMA read no report", {31'b0, wr_err_report}, 32'h0);
        clear_all();
        chk("R7 clear all", flag_rdata, 32'h0);

        // R4: odd rule, correct parity: no flag
        par_en = 1; par_even = 0; src_dma = 0; rd_done = 1;
        rd_data = 32'hA5_3C_00_FF; rd_par = good_par(rd_data, 0); cycle(); idle();
        chk("R4 odd good parity", flag_rdata, 32'h0);
        // R4: odd rule, one lane flipped
        rd_done = 1; rd_par = good_par(rd_data, 0) ^ 4'b0100; cycle(); idle();
        chk("R4 odd bad lane2", flag_rdata, 32'h1);
        // R4: even rule on DMA
        par_even = 1; src_dma = 1; rd_done = 1; rd_data = 32'h0102_0304;
        rd_par = good_par(rd_data, 1); cycle(); idle();
        chk("R4 even good parity", {31'b0, flag_rdata[4]}, 32'h0);
        rd_done = 1; rd_par = good_par(rd_data, 0); cycle(); idle();
        chk("R4 even bad parity DMA bit4", {31'b0, flag_rdata[4]}, 32'h1);
        clear_all();
        // R5: enable off or no read: no parity flags
        par_en = 0; rd_done = 1; rd_par = ~good_par(rd_data, par_even); cycle(); idle();
        chk("R5 parity disabled", flag_rdata, 32'h0);
        par_en = 1; rd_done = 0; cycle();
        chk("R5 no read completion", flag_rdata, 32'h0);
        // R8: set and clear same cycle
        src_dma = 0; rd_err_stb = 1; flag_wr = 1; flag_wdata = 32'h0; cycle(); idle();
        chk("R8 set wins", flag_rdata, 32'h4);
        clear_all();

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            src_dma    = $urandom_range(0, 1);
            rd_done    = $urandom_range(0, 1);
            par_en     = ($urandom_range(0, 3) != 0);
            par_even   = $urandom_range(0, 1);
            rd_data    = $urandom;
            rd_par     = ($urandom_range(0, 3) == 0) ? 4'($urandom) : good_par(rd_data, par_even);
            rd_err_stb = ($urandom_range(0, 7) == 0);
            wr_err_stb = ($urandom_range(0, 7) == 0);
            wr_rpt_en  = $urandom_range(0, 1);
            flag_wr    = ($urandom_range(0, 9) == 0);
            flag_wdata = $urandom;
            cycle();
        end
        idle();
        cycle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule